// File: doc/BRIEF.md
# RS-485 Automatic Driver Direction Controller

This block sits beside a UART and decides, from the serial transmit line alone, when an RS-485 line driver may drive the bus. It takes no status from the UART. A mode register holds a 3-bit code. The code selects one of three behaviours: plain RS-232 operation with the RS-485 driver parked off, full-duplex RS-485 with the driver always on, or half-duplex RS-485 at one of four fixed bit rates. In half-duplex mode a falling edge on the idle-high transmit line is taken as a start bit. The block then drives the bus for exactly one character time and turns the receiver off while doing so. When the character ends, it hands the bus back.

A second register holds a single bit that stretches the character from 10 to 11 bit times. This covers 8 data bits with a parity bit or 8 data bits with two stop bits. Bit periods come from a prescaler running on the system clock, whose frequency is a parameter. Software programs both registers through a single-cycle write strobe and reads them back through a read strobe. After that, no further software action is needed.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset the mode register reads 0, the frame register reads 0, `de_o` is 0 and `re_no` is 0.
- R2: A write with `addr_i`=0 stores `wdata_i[2:0]` as the mode code. A write with `addr_i`=1 stores `wdata_i[0]` as the long-frame bit. A read strobe returns the addressed register zero-extended on `rdata_o` in the cycle after the strobe.
- R3: With mode code 0 (RS-232), `de_o` and `re_no` stay 0 whatever happens on `tx_i`.
- R4: Mode codes 2 and 3 are reserved and behave exactly like code 0. They still read back as written.
- R5: With mode code 1 (full duplex), `de_o` is 1 from the cycle after the write onwards and `re_no` is 0, whatever happens on `tx_i`.
- R6: With mode codes 4 to 7 (half duplex), a falling edge on an idle `tx_i` raises `de_o` after the third rising clock edge that follows the edge. `re_no` equals `de_o` in this mode.
- R7: In half-duplex mode `de_o` stays high for exactly N×D clocks and then drops. N is 10, or 11 when the long-frame bit is 1. D is CLK_HZ divided by the rate: 9600 for code 4, 19200 for code 5, 57600 for code 6 and 115200 for code 7.
- R8: A start bit that begins as soon as the last stop bit ends keeps `de_o` high with no gap and times a fresh character from that edge.
- R9: Falling edges inside a character (between data bits) neither restart nor extend the character timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 1 | Register select: 0 mode, 1 long frame |
| wdata_i | input | 3 | Write data |
| rdata_o | output | 3 | Read data, registered |
| tx_i | input | 1 | Observed UART transmit line, idle high |
| de_o | output | 1 | Line driver enable, active high |
| re_no | output | 1 | Receiver enable, active low |

## Verification
Each result has a fixed due cycle. A register write or read takes effect one clock after the strobe. A start bit shows on `de_o` three clocks after `tx_i` falls: two synchroniser stages plus the state register. `de_o` then drops exactly N×D clocks after it rose. The driver task computes these due cycles from the requirements when it sends each character and queues them with the expected level. The monitor samples on the falling clock edge and compares only when the cycle count matches. Samples one clock before and one clock after each edge pin the timing down to the cycle.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

  typedef enum logic [2:0] {
    MODE_RS232   = 3'd0,
    MODE_FULL    = 3'd1,
    MODE_RSV_A   = 3'd2,
    MODE_RSV_B   = 3'd3,
    MODE_HD_9K6  = 3'd4,
    MODE_HD_19K2 = 3'd5,
    MODE_HD_57K6 = 3'd6,
    MODE_HD_115K = 3'd7
  } mode_e;

  function automatic int unsigned baud_of(input logic [1:0] sel);
    case (sel)
      2'd0:    baud_of = 9600;
      2'd1:    baud_of = 19200;
      2'd2:    baud_of = 57600;
      default: baud_of = 115200;
    endcase
  endfunction

  function automatic logic is_half(input logic [2:0] m);
    is_half = m[2];
  endfunction

  function automatic logic is_full(input logic [2:0] m);
    is_full = (m == MODE_FULL);
  endfunction

endpackage

// File: rtl/rs485_mode_regs.sv
module rs485_mode_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       addr_i,
  input  logic [2:0] wdata_i,
  output logic [2:0] rdata_o,
  output logic [2:0] mode_o,
  output logic       long_o
);
  logic [2:0] mode_q;
  logic       long_q;
  logic [2:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 3'd0;
      long_q <= 1'b0;
    end else if (wr_i) begin
      if (addr_i) long_q <= wdata_i[0];
      else        mode_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= 3'd0;
    else if (rd_i) rdata_q <= addr_i ? {2'b00, long_q} : mode_q;
  end

  assign rdata_o = rdata_q;
  assign mode_o  = mode_q;
  assign long_o  = long_q;
endmodule

// File: rtl/rs485_tx_edge.sv
module rs485_tx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_i,
  output logic fall_o
);
  logic s1_q, s2_q, d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      d_q  <= 1'b1;
    end else begin
      s1_q <= tx_i;
      s2_q <= s1_q;
      d_q  <= s2_q;
    end
  end

  assign fall_o = d_q & ~s2_q;
endmodule

// File: rtl/rs485_bit_timer.sv
module rs485_bit_timer #(
  parameter int unsigned DIV_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mid_o,
  output logic             end_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half;
  logic             last;

  assign half = div_i >> 1;
  assign last = (cnt_q == div_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= last ? '0 : cnt_q + DIV_W'(1);
    else                cnt_q <= '0;
  end

  // mid-bit step and end-of-bit boundary
  assign mid_o = run_i && !restart_i && (cnt_q == half - DIV_W'(1));
  assign end_o = run_i && !restart_i && last;
endmodule

// File: rtl/rs485_frame_ctrl.sv
module rs485_frame_ctrl #(
  parameter int unsigned SHORT_BITS = 10,
  parameter int unsigned LONG_BITS  = 11,
  parameter int unsigned BIT_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             long_i,
  input  logic             fall_i,
  input  logic             mid_i,
  input  logic             end_i,
  output logic             restart_o,
  output logic             busy_o,
  output logic [BIT_W-1:0] bits_o
);
  logic             busy_q;
  logic [BIT_W-1:0] bits_q;
  logic             start;

  // idle, or second half of the final stop bit
  assign start = en_i && fall_i && (!busy_q || bits_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      bits_q <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      bits_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      bits_q <= long_i ? BIT_W'(LONG_BITS) : BIT_W'(SHORT_BITS);
    end else if (busy_q) begin
      if (end_i && bits_q == '0)       busy_q <= 1'b0;
      else if (mid_i && bits_q != '0)  bits_q <= bits_q - BIT_W'(1);
    end
  end

  assign restart_o = start;
  assign busy_o    = busy_q;
  assign bits_o    = bits_q;
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned SHORT_BITS = 10,
  parameter int unsigned LONG_BITS  = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic       addr_i,
  input  logic [2:0] wdata_i,
  output logic [2:0] rdata_o,
  input  logic       tx_i,
  output logic       de_o,
  output logic       re_no
);
  localparam int unsigned DIV_MAX = CLK_HZ / 9600;
  localparam int unsigned DIV_W   = $clog2(DIV_MAX + 1);
  localparam int unsigned BIT_W   = $clog2(LONG_BITS + 1);

  logic [2:0]       mode_w;
  logic             long_w;
  logic             fall_w;
  logic             restart_w, busy_w, mid_w, end_w;
  logic [BIT_W-1:0] bits_w;
  logic [DIV_W-1:0] div_tab [4];
  logic [DIV_W-1:0] div_w;
  logic             half_w, full_w;

  for (genvar g = 0; g < 4; g++) begin : g_div
    localparam int unsigned D = CLK_HZ / baud_of(2'(g));
    assign div_tab[g] = DIV_W'(D);
  end

  assign div_w  = div_tab[mode_w[1:0]];
  assign half_w = is_half(mode_w);
  assign full_w = is_full(mode_w);

  rs485_mode_regs u_regs (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o,
    .mode_o(mode_w), .long_o(long_w)
  );

  rs485_tx_edge u_edge (
    .clk_i, .rst_ni, .tx_i, .fall_o(fall_w)
  );

  rs485_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i, .rst_ni, .restart_i(restart_w), .run_i(busy_w),
    .div_i(div_w), .mid_o(mid_w), .end_o(end_w)
  );

  rs485_frame_ctrl #(
    .SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS), .BIT_W(BIT_W)
  ) u_frame (
    .clk_i, .rst_ni, .en_i(half_w), .long_i(long_w), .fall_i(fall_w),
    .mid_i(mid_w), .end_i(end_w), .restart_o(restart_w),
    .busy_o(busy_w), .bits_o(bits_w)
  );

  assign de_o  = full_w | (half_w & busy_w);
  assign re_no = half_w & busy_w;
endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
module rs485_dir_ctrl_chk #(
  parameter int unsigned LONG_BITS = 11,
  parameter int unsigned BIT_W     = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       mode_i,
  input logic             fall_i,
  input logic [BIT_W-1:0] bits_i,
  input logic             de_o,
  input logic             re_no
);
  AST_PASSIVE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0 || mode_i == 3'd2 || mode_i == 3'd3) |-> (!de_o && !re_no)); // R3, R4
  AST_FULL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd1) |-> (de_o && !re_no)); // R5
  AST_RX_OPPOSITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[2] |-> (re_no == de_o)); // R6
  AST_START_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[2] && $past(mode_i[2]) && $rose(de_o)) |-> $past(fall_i)); // R6
  AST_BITS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bits_i <= BIT_W'(LONG_BITS))); // R7
endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk #(.LONG_BITS(LONG_BITS), .BIT_W(BIT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_w), .fall_i(fall_w),
  .bits_i(bits_w), .de_o(de_o), .re_no(re_no)
);

// File: tb/rs485_dir_ctrl_tb.sv
module rs485_dir_ctrl_tb;
  localparam int unsigned CLK_HZ = 1_152_000;

  typedef struct {
    int         cyc;
    int         kind;   // 0 de_o, 1 re_no, 2 rdata_o
    logic [2:0] exp;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0, rd_i = 1'b0, addr_i = 1'b0;
  logic [2:0] wdata_i = 3'd0;
  logic [2:0] rdata_o;
  logic       tx_i = 1'b1;
  logic       de_o, re_no;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  item_t q[$];

  rs485_dir_ctrl #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk_i(clk), .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o,
    .tx_i, .de_o, .re_no
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic expect_at(input int c, input int kind, input logic [2:0] exp, input string req);
    item_t it;
    it.cyc = c; it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  // monitor: compare queued expectations on the falling edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      it = q.pop_front();
      if (it.cyc < cyc) check(it.req, "missed sample", cyc, it.cyc);
      else case (it.kind)
        0:       check(it.req, "de_o", int'(de_o), int'(it.exp[0]));
        1:       check(it.req, "re_no", int'(re_no), int'(it.exp[0]));
        default: check(it.req, "rdata_o", int'(rdata_o), int'(it.exp));
      endcase
    end
  end

  task automatic write_reg(input logic a, input logic [2:0] d);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic read_reg(input logic a, input logic [2:0] exp, input string req);
    @(negedge clk);
    rd_i = 1'b1; addr_i = a;
    expect_at(cyc + 1, 2, exp, req);
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  // one character on tx_i; div in clocks per bit, nb 10 or 11
  task automatic send_char(input logic [7:0] data, input int nb, input int div,
                           input bit hd, input logic cde, input bit gap_before,
                           input bit more, input string req);
    logic [10:0] bits;
    int m;
    bits = 11'h7FF;
    bits[0] = 1'b0;
    bits[8:1] = data;
    if (nb == 11) bits[9] = ^data;
    @(negedge clk);
    m = cyc;
    if (hd) begin
      if (gap_before) expect_at(m + 2, 0, 3'd0, req);
      expect_at(m + 3, 0, 3'd1, "R6");
      expect_at(m + 3, 1, 3'd1, "R6");
      expect_at(m + 3 + nb * div / 2, 0, 3'd1, "R9");
      expect_at(m + 2 + nb * div, 0, 3'd1, req);
      if (!more) begin
        expect_at(m + 3 + nb * div, 0, 3'd0, req);
        expect_at(m + 3 + nb * div, 1, 3'd0, req);
      end
    end else begin
      expect_at(m + 3, 0, {2'b00, cde}, req);
      expect_at(m + 3, 1, 3'd0, req);
      expect_at(m + nb * div / 2, 0, {2'b00, cde}, req);
    end
    for (int i = 0; i < nb; i++) begin
      tx_i = bits[i];
      if (i == 0) repeat (div - 1) @(negedge clk);
      else        repeat (div) @(negedge clk);
    end
    if (!more) repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "de_o in reset", int'(de_o), 0);
    check("R1", "re_no in reset", int'(re_no), 0);
    rst_ni = 1'b1;
    read_reg(1'b0, 3'd0, "R1");
    read_reg(1'b1, 3'd0, "R1");

    // full duplex
    write_reg(1'b0, 3'd1);
    check("R5", "de_o after write", int'(de_o), 1);
    read_reg(1'b0, 3'd1, "R2");
    send_char(8'hA5, 10, 10, 1'b0, 1'b1, 1'b0, 1'b0, "R5");

    // RS-232 and reserved codes
    write_reg(1'b0, 3'd0);
    check("R3", "de_o after write", int'(de_o), 0);
    send_char(8'h3C, 10, 10, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    write_reg(1'b0, 3'd2);
    read_reg(1'b0, 3'd2, "R4");
    send_char(8'h55, 10, 10, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
    write_reg(1'b0, 3'd3);
    read_reg(1'b0, 3'd3, "R4");
    send_char(8'h00, 10, 10, 1'b0, 1'b0, 1'b0, 1'b0, "R4");

    // half duplex, each rate: D = CLK_HZ / rate
    write_reg(1'b0, 3'd7);
    send_char(8'h55, 10, CLK_HZ / 115200, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    write_reg(1'b1, 3'd1);
    read_reg(1'b1, 3'd1, "R2");
    send_char(8'hAA, 11, CLK_HZ / 115200, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    write_reg(1'b1, 3'd0);
    write_reg(1'b0, 3'd4);
    send_char(8'h5A, 10, CLK_HZ / 9600, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    write_reg(1'b0, 3'd5);
    send_char(8'h01, 10, CLK_HZ / 19200, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    write_reg(1'b0, 3'd6);
    send_char(8'hF0, 10, CLK_HZ / 57600, 1'b1, 1'b0, 1'b1, 1'b0, "R7");

    // back-to-back characters
    write_reg(1'b0, 3'd7);
    send_char(8'h55, 10, CLK_HZ / 115200, 1'b1, 1'b0, 1'b1, 1'b1, "R8");
    send_char(8'h33, 10, CLK_HZ / 115200, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
    send_char(8'h0F, 10, CLK_HZ / 115200, 1'b1, 1'b0, 1'b0, 1'b0, "R8");

    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule